// File: doc/BRIEF.md
# Residue Multiply-Accumulate Channel

This block is one lane of a residue-number-system multiply-accumulate datapath. The modulus is a parameter, and every residue the lane handles is 5 bits wide. Suitable moduli are 17, 19, 23, 25, 27, 29, 31 and 32. Each accepted cycle takes a signed 8-bit sample and a coefficient that has already been reduced to a residue. The sample is converted to the lane's residue, the two residues are multiplied, and the product is folded into a running sum.

The running sum lives in carry-save form as a sum vector, a carry vector and a two-bit overflow tag. No carry ripples through it while terms are added. The multiplier output goes into the compressor unreduced. A read request adds the redundant parts, reduces the result to a canonical residue and presents it one cycle later.

Negative operands use the residue complement: the negative of a value with residue r is written m - r. The multiplier has no sign logic. A product of complemented operands is already the complement of the true product.

Top module: `residue_mac_channel`

## Requirements
- R1: After reset, res_vld is 0 and res_out is 0. A read issued before any accumulation returns 0.
- R2: data_in is a two's complement 8-bit value d. It contributes the residue d mod m in 0..m-1, so a negative d maps to m - (|d| mod m) unless that remainder is 0.
- R3: In a cycle with in_vld high, the accumulator gains (d mod m) * coef_in modulo m. coef_in must be below m whenever in_vld is high.
- R4: In a cycle with in_vld and clr both low, the accumulated residue does not change, whatever data_in and coef_in carry.
- R5: clr together with in_vld makes the accumulator equal to that cycle's product alone. clr with in_vld low makes it 0.
- R6: rd_req in cycle t makes res_vld high in cycle t+1 only. res_out then shows the accumulated residue as it stood before any update in cycle t. Without rd_req, res_out holds its value.
- R7: Whenever res_vld is high, res_out is below m.
- R8: A coefficient given as m - r adds the complement of the product with r. Equal positive and complemented terms therefore cancel to 0.
- R9: Reading is non-destructive. Back-to-back reads with no accumulation between them return the same residue.
- R10: Results stay correct after hundreds of consecutive accumulations, in which the redundant vectors overflow their width many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Restart the accumulation |
| in_vld | input | 1 | Accept data_in and coef_in this cycle |
| data_in | input | 8 | Signed sample, two's complement |
| coef_in | input | 5 | Coefficient residue, below m |
| rd_req | input | 1 | Resolve and present the accumulated residue |
| res_out | output | 5 | Canonical accumulated residue |
| res_vld | output | 1 | res_out was updated by the previous cycle's read |

## Verification
A read and an accumulation, or a read and a clear, can land in the same cycle. The defined outcome is that the read returns the value from before that cycle's update. The update still takes effect for the next read. The stimulus table and the directed tests raise rd_req together with in_vld, and also together with clr plus in_vld. Each read result is compared against a bench model that records the expected residue before applying that cycle's update. A follow-up read then confirms that the product or the clear landed.

// File: rtl/residue_mac_channel.sv
module residue_mac_channel #(
  parameter int MOD = 23,
  parameter int DW  = 8,
  parameter int RW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_vld,
  input  logic [DW-1:0] data_in,
  input  logic [RW-1:0] coef_in,
  input  logic          rd_req,
  output logic [RW-1:0] res_out,
  output logic          res_vld
);
  localparam int PW   = 2 * RW;
  localparam int AW   = PW + 1;
  localparam int FOLD = (1 << AW) % MOD;
  localparam int OFF  = MOD * (((1 << (DW - 1)) + MOD - 1) / MOD);

  logic [AW-1:0] s_q, c_q;
  logic [1:0]    f_q;

  // forward conversion: shift into a non-negative range by a multiple of MOD
  logic [DW+1:0] d_pos;
  logic [RW-1:0] d_res;
  assign d_pos = {{2{data_in[DW-1]}}, data_in} + (DW+2)'(OFF);
  assign d_res = RW'(d_pos % (DW+2)'(MOD));

  logic [PW-1:0] prod;
  assign prod = {{RW{1'b0}}, d_res} * {{RW{1'b0}}, coef_in};

  logic [AW-1:0] fk;
  always_comb begin
    case (f_q)
      2'b00:   fk = '0;
      2'b11:   fk = AW'(2 * FOLD);
      default: fk = AW'(FOLD);
    endcase
  end

  logic [AW-1:0] op_a, op_b, op_k, op_p;
  assign op_a = clr ? '0 : s_q;
  assign op_b = clr ? '0 : c_q;
  assign op_k = clr ? '0 : fk;
  assign op_p = {1'b0, prod};

  logic [AW-1:0] x1, y1, cv1, x2, y2, cv2;
  assign x1  = op_a ^ op_b ^ op_p;
  assign y1  = (op_a & op_b) | (op_a & op_p) | (op_b & op_p);
  assign cv1 = {y1[AW-2:0], 1'b0};
  assign x2  = x1 ^ cv1 ^ op_k;
  assign y2  = (x1 & cv1) | (x1 & op_k) | (cv1 & op_k);
  assign cv2 = {y2[AW-2:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0;
      c_q <= '0;
      f_q <= '0;
    end else if (in_vld) begin
      s_q <= x2;
      c_q <= cv2;
      f_q <= {y1[AW-1], y2[AW-1]};
    end else if (clr) begin
      s_q <= '0;
      c_q <= '0;
      f_q <= '0;
    end
  end

  logic [AW+1:0] total;
  assign total = {2'b00, s_q} + {2'b00, c_q} + {2'b00, fk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_out <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= rd_req;
      if (rd_req) res_out <= RW'(total % (AW+2)'(MOD));
    end
  end
endmodule

// File: rtl/residue_mac_channel_chk.sv
module residue_mac_channel_chk #(
  parameter int MOD = 23,
  parameter int RW  = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          in_vld,
  input logic [RW-1:0] coef_in,
  input logic          rd_req,
  input logic [RW-1:0] res_out,
  input logic          res_vld
);
  p_out_below_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (int'(res_out) < MOD));

  p_coef_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> (int'(coef_in) < MOD));

  p_read_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> res_vld);

  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!res_vld && $stable(res_out)));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !in_vld && !clr) ##1 rd_req |=> (res_out == $past(res_out)));

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !in_vld) ##1 rd_req |=> (res_out == '0));
endmodule

bind residue_mac_channel residue_mac_channel_chk #(.MOD(MOD), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .coef_in(coef_in),
  .rd_req(rd_req), .res_out(res_out), .res_vld(res_vld)
);

// File: tb/residue_mac_channel_bench.sv
`timescale 1ns/1ps
module residue_mac_channel_bench;
  localparam int MOD = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, in_vld = 1'b0, rd_req = 1'b0;
  logic [7:0] data_in = '0;
  logic [4:0] coef_in = '0;
  logic [4:0] res_out;
  logic res_vld;

  int tests = 0, fails = 0, acc = 0;

  always #4 clk = ~clk;

  residue_mac_channel #(.MOD(MOD)) u_residue_mac_channel (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .data_in(data_in),
    .coef_in(coef_in), .rd_req(rd_req), .res_out(res_out), .res_vld(res_vld)
  );

  // {clr, vld, rd, data[7:0], coef[4:0]}
  localparam logic [15:0] VEC [0:15] = '{
    {3'b110, 8'd10,  5'd3},  {3'b010, 8'd200, 5'd7},
    {3'b011, 8'd45,  5'd22}, {3'b001, 8'd99,  5'd5},
    {3'b010, 8'd255, 5'd1},  {3'b011, 8'd128, 5'd11},
    {3'b100, 8'd7,   5'd4},  {3'b001, 8'd0,   5'd0},
    {3'b010, 8'd127, 5'd21}, {3'b111, 8'd23,  5'd9},
    {3'b011, 8'd46,  5'd17}, {3'b000, 8'd3,   5'd2},
    {3'b010, 8'd250, 5'd19}, {3'b011, 8'd66,  5'd0},
    {3'b001, 8'd1,   5'd1},  {3'b011, 8'd90,  5'd13}
  };

  function automatic int md(input int x);
    return ((x % MOD) + MOD) % MOD;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic v, input logic [7:0] d,
                      input logic [4:0] k, input logic r, input string req);
    int exp, pv;
    exp = acc;
    pv = md(md(int'($signed(d))) * int'(k));
    if (c && v) acc = pv;
    else if (c) acc = 0;
    else if (v) acc = md(acc + pv);
    clr = c; in_vld = v; data_in = d; coef_in = k; rd_req = r;
    @(negedge clk);
    if (r) check(res_vld === 1'b1 && int'(res_out) == exp, req, int'(res_out), exp);
    else   check(res_vld === 1'b0, req, int'(res_vld), 0);
    clr = 0; in_vld = 0; rd_req = 0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res_vld === 1'b0 && res_out === 5'd0, "R1 reset state", int'(res_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 8'd0, 5'd0, 1, "R1 read after reset");

    for (int i = 0; i < 16; i++)
      step(VEC[i][15], VEC[i][14], VEC[i][12:5], VEC[i][4:0], VEC[i][13], "R3 R6 table");

    // R2: forward conversion of extreme and negative samples
    step(1, 1, 8'h80, 5'd1, 1, "R2 setup");
    step(0, 0, 8'd0, 5'd0, 1, "R2 -128 mod m");
    step(1, 1, 8'hFF, 5'd1, 0, "R2 setup");
    step(0, 0, 8'd0, 5'd0, 1, "R2 -1 mod m");
    step(1, 1, 8'd127, 5'd1, 0, "R2 setup");
    step(0, 0, 8'd0, 5'd0, 1, "R2 127 mod m");
    step(1, 1, 8'hE9, 5'd1, 0, "R2 setup");
    step(0, 0, 8'd0, 5'd0, 1, "R2 -23 maps to 0");

    // R8: complemented coefficient cancels
    step(1, 1, 8'd5, 5'd3, 0, "R8 setup");
    step(0, 1, 8'd5, 5'(MOD - 3), 1, "R8 before cancel");
    step(0, 0, 8'd0, 5'd0, 1, "R8 cancel to zero");
    step(1, 1, 8'hFB, 5'(MOD - 3), 0, "R8 setup");
    step(0, 0, 8'd0, 5'd0, 1, "R8 neg times neg");

    // R4: idle cycles with busy inputs
    step(1, 1, 8'd9, 5'd8, 0, "R4 setup");
    step(0, 0, 8'd77, 5'd21, 0, "R4 idle");
    step(0, 0, 8'h90, 5'd13, 0, "R4 idle");
    step(0, 0, 8'd0, 5'd0, 1, "R4 held value");

    // R9: repeated reads
    step(0, 0, 8'd0, 5'd0, 1, "R9 second read");
    step(0, 0, 8'd0, 5'd0, 1, "R9 third read");

    // R5: clear with and without a product, alongside reads
    step(1, 0, 8'd50, 5'd6, 1, "R5 read during clear");
    step(0, 0, 8'd0, 5'd0, 1, "R5 cleared to zero");
    step(1, 1, 8'd50, 5'd6, 1, "R5 read during clear+acc");
    step(0, 0, 8'd0, 5'd0, 1, "R5 product only");

    // R10: long run forcing many overflow folds
    step(1, 0, 8'd0, 5'd0, 0, "R10 setup");
    for (int i = 0; i < 300; i++) step(0, 1, 8'd127, 5'd22, 0, "R10 run");
    step(0, 0, 8'd0, 5'd0, 1, "R10 long sum");
    for (int i = 0; i < 200; i++) step(0, 1, 8'(i * 37), 5'(i % MOD), (i % 50) == 49, "R10 R7 mixed");
    step(0, 0, 8'd0, 5'd0, 1, "R10 mixed sum");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule